// File: doc/BRIEF.md
# Conversion-on-Read Monitor ADC Target

This block is the two-wire serial (I2C) target side of a multi-channel monitor converter. It watches SCL and SDA, answers at a command-space address that it works out from a configuration-space base address, and holds a channel pointer. A controller first writes an offset byte, and bits 6:3 of that byte name one of eleven channels. The channels in index order are supply rails A to F (0 to 5), VDD (6), the 12 V input (7), die temperature (8), auxiliary input 1 (9) and auxiliary input 2 (10).

The next read to the target is refused at its address byte on purpose. That refusal (a NACK) is the event that starts a conversion. The block asks an external sample port for the selected channel and runs a conversion timer for a time given in clock cycles. Once the timer has run out and the sample has arrived, a read returns a 16-bit word, high byte first. The word carries the channel index next to the 10-bit sample, so the controller can confirm which channel it got. The analog converter sits outside the block and connects through a request/acknowledge port.

Top module: `mon_adc_tgt`

## Requirements
- R1: The target answers only at the 7-bit address `cmd_addr_o = (cfg_addr_i & 7'h07) | 7'h48`. With a base of 0x50 this is 0x48, and with a base of 0x57 it is 0x4F. An address byte for any other address gets no ACK, and SDA is not driven.
- R2: A write to the target is ACKed on its address byte and on every data byte. Each data byte loads the channel pointer from its bits 6:3. Bits 7 and 2:0 are ignored.
- R3: A read that follows a pointer write is NACKed on its address byte. That NACK starts a conversion: `adc_req_o` rises and `adc_chan_o` carries the pointer.
- R4: While a conversion is pending, every read is NACKed on its address byte and no new conversion starts.
- R5: Once a conversion has finished, a read is ACKed and returns two bytes, high byte first. The 16-bit word holds the channel index in bits 14:11 and the sample in bits 9:0. Bits 15 and 10 are zero.
- R6: `adc_req_o` stays high, and `adc_chan_o` stays stable, until a cycle in which `adc_ack_i` is high. `adc_data_i` is captured in that cycle, and `adc_req_o` is low in the next cycle.
- R7: A conversion lasts CONV_CYCLES = (CLK_HZ / 1e6) × CONV_US clock cycles (70 µs gives 3500 cycles at 50 MHz). A read whose address byte ends before that time is NACKed. A read after it is ACKed, provided the sample has arrived.
- R8: The pointer and the last result are kept until the next offset write. A repeated read returns the same word and starts no conversion. A write made of the address byte alone does not arm a conversion.
- R9: A STOP returns the target to idle. If the controller NACKs the high byte, the read ends. The next transaction is then handled normally.
- R10: The target changes what it drives on SDA only while SCL is low.
- R11: All eleven channel indices (0 to 10) are accepted and echoed unchanged in bits 14:11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr_i | input | 7 | Configuration-space base address |
| cmd_addr_o | output | 7 | Derived command-space address the target answers at |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull SDA low when high (open drain) |
| adc_req_o | output | 1 | Sample request to the converter |
| adc_chan_o | output | 4 | Channel index for the requested sample |
| adc_ack_i | input | 1 | Converter acknowledge; sample valid this cycle |
| adc_data_i | input | 10 | Converter sample |

## Verification
The hardest case to reach from the ports is a read that arrives while a conversion is pending. The other hard case is where the conversion window ends relative to the address byte of a later read. The bench records the cycle in which `adc_req_o` rises and uses it as the start of the conversion. It then starts one read early enough that its address byte ends well before CONV_CYCLES have passed, and a second read just after the window has closed. It also issues a read straight after a NACK-triggered start, which lands deep inside the pending window, and checks that no second request appears.

// File: rtl/mon_adc_pkg.sv
package mon_adc_pkg;

    localparam int CHAN_W   = 4;
    localparam int SAMPLE_W = 10;
    localparam int WORD_W   = 16;

    localparam logic [6:0] CMD_SPACE_TAG = 7'h48;
    localparam logic [6:0] BASE_CLR_MASK = 7'h78;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_WDATA,
        ST_RBYTE,
        ST_RMACK,
        ST_IGNORE
    } tgt_state_e;

    function automatic logic [6:0] cmd_addr_of(input logic [6:0] cfg);
        return (cfg & ~BASE_CLR_MASK) | CMD_SPACE_TAG;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input logic [CHAN_W-1:0] ch,
                                                    input logic [SAMPLE_W-1:0] d);
        return {1'b0, ch, 1'b0, d};
    endfunction

endpackage

// File: rtl/mon_adc_line_sync.sv
module mon_adc_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t q, d;
    logic scl_s, sda_s;

    assign scl_s = q.scl_pipe[STAGES-1];
    assign sda_s = q.sda_pipe[STAGES-1];

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[STAGES-2:0], scl_i};
        d.sda_pipe = {q.sda_pipe[STAGES-2:0], sda_i};
        d.scl_prev = scl_s;
        d.sda_prev = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign sda_o      = sda_s;
    assign scl_rise_o = scl_s & ~q.scl_prev;
    assign scl_fall_o = ~scl_s & q.scl_prev;
    assign start_o    = scl_s & q.scl_prev & ~sda_s & q.sda_prev;
    assign stop_o     = scl_s & q.scl_prev & sda_s & ~q.sda_prev;

endmodule

// File: rtl/mon_adc_conv.sv
module mon_adc_conv
    import mon_adc_pkg::*;
#(
    parameter int CONV_CYCLES = 3500,
    localparam int CNT_W = $clog2(CONV_CYCLES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [CHAN_W-1:0]   chan_i,
    input  logic                adc_ack_i,
    input  logic [SAMPLE_W-1:0] adc_data_i,
    output logic                busy_o,
    output logic                adc_req_o,
    output logic [CHAN_W-1:0]   adc_chan_o,
    output logic [WORD_W-1:0]   word_o
);
    typedef struct packed {
        logic                busy;
        logic                req;
        logic                have;
        logic [CNT_W-1:0]    cnt;
        logic [CHAN_W-1:0]   chan;
        logic [SAMPLE_W-1:0] data;
    } conv_t;

    conv_t q, d;

    always_comb begin
        logic got;
        d   = q;
        got = q.req & adc_ack_i;
        if (start_i && !q.busy) begin
            d.busy = 1'b1;
            d.req  = 1'b1;
            d.have = 1'b0;
            d.cnt  = CNT_W'(CONV_CYCLES - 1);
            d.chan = chan_i;
        end else if (q.busy) begin
            if (q.cnt != '0) d.cnt = q.cnt - 1'b1;
            if (got) begin
                d.req  = 1'b0;
                d.have = 1'b1;
                d.data = adc_data_i;
            end
            if (q.cnt == '0 && (q.have || got)) d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o     = q.busy;
    assign adc_req_o  = q.req;
    assign adc_chan_o = q.chan;
    assign word_o     = pack_word(q.chan, q.data);

endmodule

// File: rtl/mon_adc_tgt_fsm.sv
module mon_adc_tgt_fsm
    import mon_adc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [6:0]        my_addr_i,
    input  logic              busy_i,
    input  logic [WORD_W-1:0] result_i,
    output logic              sda_oe_o,
    output logic              conv_start_o,
    output logic [CHAN_W-1:0] ptr_o
);
    typedef struct packed {
        tgt_state_e        st;
        logic [3:0]        bitcnt;
        logic [7:0]        sh;
        logic              oe;
        logic              armed;
        logic [CHAN_W-1:0] ptr;
        logic              rd;
        logic              lo_sent;
        logic              mack;
        logic              conv_start;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d            = q;
        d.conv_start = 1'b0;
        if (stop_i) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_i) begin
            d.st     = ST_ADDR;
            d.bitcnt = '0;
            d.oe     = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (scl_rise_i && q.bitcnt < 4'd8) begin
                        d.sh     = {q.sh[6:0], sda_i};
                        d.bitcnt = q.bitcnt + 1'b1;
                    end else if (scl_fall_i && q.bitcnt == 4'd8) begin
                        if (q.sh[7:1] != my_addr_i) begin
                            d.st = ST_IGNORE;
                        end else if (!q.sh[0]) begin
                            d.rd = 1'b0;
                            d.oe = 1'b1;
                            d.st = ST_ACK;
                        end else if (busy_i) begin
                            d.st = ST_IGNORE;
                        end else if (q.armed) begin
                            d.st         = ST_IGNORE;
                            d.armed      = 1'b0;
                            d.conv_start = 1'b1;
                        end else begin
                            d.rd      = 1'b1;
                            d.lo_sent = 1'b0;
                            d.sh      = result_i[15:8];
                            d.oe      = 1'b1;
                            d.st      = ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        if (q.rd) begin
                            d.oe     = ~q.sh[7];
                            d.sh     = {q.sh[6:0], 1'b0};
                            d.bitcnt = 4'd1;
                            d.st     = ST_RBYTE;
                        end else begin
                            d.oe     = 1'b0;
                            d.bitcnt = '0;
                            d.st     = ST_WDATA;
                        end
                    end
                end
                ST_WDATA: begin
                    if (scl_rise_i && q.bitcnt < 4'd8) begin
                        d.sh     = {q.sh[6:0], sda_i};
                        d.bitcnt = q.bitcnt + 1'b1;
                    end else if (scl_fall_i && q.bitcnt == 4'd8) begin
                        d.ptr   = q.sh[6:3];
                        d.armed = 1'b1;
                        d.oe    = 1'b1;
                        d.st    = ST_ACK;
                    end
                end
                ST_RBYTE: begin
                    if (scl_fall_i) begin
                        if (q.bitcnt < 4'd8) begin
                            d.oe     = ~q.sh[7];
                            d.sh     = {q.sh[6:0], 1'b0};
                            d.bitcnt = q.bitcnt + 1'b1;
                        end else begin
                            d.oe   = 1'b0;
                            d.mack = 1'b0;
                            d.st   = ST_RMACK;
                        end
                    end
                end
                ST_RMACK: begin
                    if (scl_rise_i) begin
                        d.mack = ~sda_i;
                    end else if (scl_fall_i) begin
                        if (q.mack && !q.lo_sent) begin
                            d.lo_sent = 1'b1;
                            d.oe      = ~result_i[7];
                            d.sh      = {result_i[6:0], 1'b0};
                            d.bitcnt  = 4'd1;
                            d.st      = ST_RBYTE;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o     = q.oe;
    assign conv_start_o = q.conv_start;
    assign ptr_o        = q.ptr;

endmodule

// File: rtl/mon_adc_tgt.sv
module mon_adc_tgt
    import mon_adc_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int CONV_US     = 70,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [6:0]          cfg_addr_i,
    output logic [6:0]          cmd_addr_o,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe_o,
    output logic                adc_req_o,
    output logic [CHAN_W-1:0]   adc_chan_o,
    input  logic                adc_ack_i,
    input  logic [SAMPLE_W-1:0] adc_data_i
);
    localparam int CONV_CYCLES = (CLK_HZ / 1_000_000) * CONV_US;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic busy, conv_start;
    logic [CHAN_W-1:0] ptr;
    logic [WORD_W-1:0] result;

    assign cmd_addr_o = cmd_addr_of(cfg_addr_i);

    mon_adc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    mon_adc_tgt_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sda_i        (sda_s),
        .scl_rise_i   (scl_rise),
        .scl_fall_i   (scl_fall),
        .start_i      (start_det),
        .stop_i       (stop_det),
        .my_addr_i    (cmd_addr_o),
        .busy_i       (busy),
        .result_i     (result),
        .sda_oe_o     (sda_oe_o),
        .conv_start_o (conv_start),
        .ptr_o        (ptr)
    );

    mon_adc_conv #(.CONV_CYCLES(CONV_CYCLES)) u_conv (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (conv_start),
        .chan_i     (ptr),
        .adc_ack_i  (adc_ack_i),
        .adc_data_i (adc_data_i),
        .busy_o     (busy),
        .adc_req_o  (adc_req_o),
        .adc_chan_o (adc_chan_o),
        .word_o     (result)
    );

endmodule

// File: rtl/mon_adc_tgt_chk.sv
module mon_adc_tgt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic       adc_req_o,
    input logic [3:0] adc_chan_o,
    input logic       adc_ack_i
);
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req_o && !adc_ack_i |=> adc_req_o);

    assert_chan_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req_o && !adc_ack_i |=> $stable(adc_chan_o));

    assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req_o && adc_ack_i |=> !adc_req_o);

    assert_nack_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_req_o) |-> !sda_oe_o);

    assert_sda_low_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

endmodule

bind mon_adc_tgt mon_adc_tgt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe_o   (sda_oe_o),
    .adc_req_o  (adc_req_o),
    .adc_chan_o (adc_chan_o),
    .adc_ack_i  (adc_ack_i)
);

// File: tb/mon_adc_tgt_tb.sv
`timescale 1ns/1ps
module mon_adc_tgt_tb;
    localparam int CONV     = 50 * 70;
    localparam int Q        = 25;
    localparam int STUB_DLY = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [6:0] cfg_addr = 7'h50;
    logic [6:0] cmd_addr;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, adc_req, adc_ack;
    logic [3:0] adc_chan;
    logic [9:0] adc_data;
    wire  sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    mon_adc_tgt u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_addr_i(cfg_addr), .cmd_addr_o(cmd_addr),
        .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .adc_req_o(adc_req), .adc_chan_o(adc_chan),
        .adc_ack_i(adc_ack), .adc_data_i(adc_data)
    );

    int checks = 0, errs = 0, cyc = 0, seed = 1;
    int conv_starts = 0, rise_cyc = 0;
    logic [3:0] last_chan = '0;
    bit done = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] got_word;
    event        rx_ev;

    function automatic logic [9:0] sample_of(input logic [3:0] ch, input int s);
        return 10'((int'(ch) * 97 + s * 31 + 5) & 10'h3FF);
    endfunction

    function automatic logic [15:0] word_of(input logic [3:0] ch, input logic [9:0] dv);
        return {1'b0, ch, 1'b0, dv};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // converter stub
    initial begin
        logic req_prev = 1'b0;
        int   cnt = 0;
        adc_ack  = 1'b0;
        adc_data = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (adc_ack) adc_ack = 1'b0;
            else if (adc_req) begin
                if (!req_prev) begin
                    conv_starts++;
                    rise_cyc  = cyc;
                    last_chan = adc_chan;
                    cnt = 0;
                end
                cnt++;
                if (cnt == STUB_DLY) begin
                    adc_ack  = 1'b1;
                    adc_data = sample_of(adc_chan, seed);
                end
            end
            req_prev = adc_req;
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(rx_ev);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected readback", int'(got_word), 0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(got_word == e, t, "readback word", int'(got_word), int'(e));
            end
        end
    end

    task automatic ph();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; ph(); scl_m = 1'b1; ph(); sda_m = 1'b0; ph(); scl_m = 1'b0; ph();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; ph(); scl_m = 1'b1; ph(); sda_m = 1'b1; ph();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; ph(); scl_m = 1'b1; ph(); scl_m = 1'b0; ph();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; ph(); scl_m = 1'b1; ph(); b = sda_line; scl_m = 1'b0; ph();
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!give_ack);
        sda_m = 1'b1;
    endtask

    task automatic wr_ptr(input logic [6:0] a, input logic [7:0] off,
                          output bit ack_a, output bit ack_d);
        i2c_start();
        send_byte({a, 1'b0}, ack_a);
        ack_d = 1'b0;
        if (ack_a) send_byte(off, ack_d);
        i2c_stop();
    endtask

    task automatic rd(input logic [6:0] a, input int nbytes,
                      output bit acked, output logic [15:0] w);
        logic [7:0] hi, lo;
        hi = '0; lo = '0;
        i2c_start();
        send_byte({a, 1'b1}, acked);
        if (acked) begin
            recv_byte(nbytes == 2, hi);
            if (nbytes == 2) recv_byte(1'b0, lo);
        end
        i2c_stop();
        w = {hi, lo};
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // full convert-and-read with scoreboard
    task automatic convert(input logic [7:0] off, input logic [3:0] ch, input string tag);
        bit a1, a2, ack;
        logic [15:0] w;
        int n0;
        wr_ptr(cmd_addr, off, a1, a2);
        chk(a1 && a2, "R2", "pointer write acks", {a1, a2}, 3);
        n0 = conv_starts;
        rd(cmd_addr, 2, ack, w);
        chk(!ack, "R3", "trigger read NACK", ack, 0);
        chk(conv_starts == n0 + 1, "R3", "one conversion started", conv_starts, n0 + 1);
        chk(last_chan == ch, "R3", "requested channel", last_chan, ch);
        wait_cyc(rise_cyc + CONV + 50);
        exp_q.push_back(word_of(ch, sample_of(ch, seed)));
        tag_q.push_back(tag);
        rd(cmd_addr, 2, ack, w);
        chk(ack, "R5", "result read ACK", ack, 1);
        if (ack) begin
            got_word = w;
            ->rx_ev;
            #1;
        end
    endtask

    initial begin
        bit ack, a1, a2;
        logic [15:0] w, prev;
        int n0;

        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0, "R10", "reset sda_oe", sda_oe, 0);
        chk(adc_req == 1'b0, "R6", "reset adc_req", adc_req, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(cmd_addr == 7'h48, "R1", "cmd address from base 0x50", cmd_addr, 'h48);

        // R4: read during pending conversion
        seed = 3;
        wr_ptr(cmd_addr, 8'h28, a1, a2);
        chk(a1 && a2, "R2", "pointer write acks", {a1, a2}, 3);
        n0 = conv_starts;
        rd(cmd_addr, 2, ack, w);
        chk(!ack, "R3", "trigger read NACK", ack, 0);
        chk(last_chan == 4'd5, "R3", "requested channel", last_chan, 5);
        rd(cmd_addr, 2, ack, w);
        chk(!ack, "R4", "read while pending NACK", ack, 0);
        chk(conv_starts == n0 + 1, "R4", "no extra conversion", conv_starts, n0 + 1);
        wait_cyc(rise_cyc + CONV + 50);
        rd(cmd_addr, 2, ack, w);
        chk(ack && w == word_of(4'd5, sample_of(4'd5, 3)), "R5", "word after wait",
            w, word_of(4'd5, sample_of(4'd5, 3)));
        chk(w[15] == 1'b0 && w[10] == 1'b0, "R5", "bits 15 and 10 zero", {w[15], w[10]}, 0);

        // R8: repeated read returns same word, no new conversion
        prev = w;
        n0 = conv_starts;
        rd(cmd_addr, 2, ack, w);
        chk(ack && w == prev, "R8", "repeated read same word", w, prev);
        chk(conv_starts == n0, "R8", "repeated read no conversion", conv_starts, n0);

        // R2 + R11: ignored offset bits, channel 10 and 0
        seed = 7;
        convert(8'hD7, 4'd10, "R11");
        seed = 11;
        convert(8'h87, 4'd0, "R2");
        seed = 2;
        convert(8'h40, 4'd8, "R5");

        // R8: address-only write does not arm
        prev = word_of(4'd8, sample_of(4'd8, 2));
        i2c_start(); send_byte({cmd_addr, 1'b0}, a1); i2c_stop();
        n0 = conv_starts;
        rd(cmd_addr, 2, ack, w);
        chk(ack && w == prev, "R8", "address-only write keeps result", w, prev);
        chk(conv_starts == n0, "R8", "address-only write no conversion", conv_starts, n0);

        // R9: controller NACKs the high byte, then a normal transaction
        rd(cmd_addr, 1, ack, w);
        chk(ack && w[15:8] == prev[15:8], "R9", "single byte read", w[15:8], prev[15:8]);
        rd(cmd_addr, 2, ack, w);
        chk(ack && w == prev, "R9", "read after early end", w, prev);

        // R7: window boundary
        seed = 5;
        wr_ptr(cmd_addr, 8'h18, a1, a2);
        rd(cmd_addr, 2, ack, w);
        chk(!ack, "R7", "trigger NACK", ack, 0);
        wait_cyc(rise_cyc + CONV - 1200);
        rd(cmd_addr, 2, ack, w);
        chk(!ack, "R7", "read just before window end NACK", ack, 0);
        wait_cyc(rise_cyc + CONV + 20);
        rd(cmd_addr, 2, ack, w);
        chk(ack && w == word_of(4'd3, sample_of(4'd3, 5)), "R7", "read after window",
            w, word_of(4'd3, sample_of(4'd3, 5)));

        // R1: foreign address and relocated base
        rd(7'h50, 2, ack, w);
        chk(!ack, "R1", "config address not answered", ack, 0);
        cfg_addr = 7'h57;
        repeat (3) @(negedge clk);
        chk(cmd_addr == 7'h4F, "R1", "cmd address from base 0x57", cmd_addr, 'h4F);
        wr_ptr(7'h48, 8'h10, a1, a2);
        chk(!a1, "R1", "old address ignored", a1, 0);
        seed = 9;
        convert(8'h10, 4'd2, "R1");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog (R9 flow) actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule